// File: doc/BRIEF.md
# Byte-Serial Timing Register Loader

This block fills a bank of 16-bit timing registers through an 8-bit data port. A load strobe, active low, marks each transfer. The strobe comes from outside the pixel clock domain, so the block resynchronises it and acts once on each falling edge. A select input chooses between two paths. On the address path the byte sets the register pointer. On the data path the byte is one half of a register word. The low half comes first and the high half follows on the next strobe.

In automatic mode the pointer advances once after each complete word. After the last register it wraps to register 0. In manual mode the pointer stays where it was put. A pointer value past the last register is a scan address. While the pointer holds a scan address, the timing engine stops and a read port shows the contents of one register. The register shown is the scan address minus the register count. Data bytes at a scan address are ignored. Loading any register address lets the engine run again with its registers untouched.

Top module: `byte_loader`

## Requirements
- R1: Two data-path strobes make one word: the first byte is bits 7:0 and the second is bits 15:8. The word is written to the register the pointer names.
- R2: In automatic mode (`manual_mode`=0) the pointer moves to the next register once the high byte is written. From register NUM_REGS-1 it wraps to 0.
- R3: An address-path strobe loads the pointer from the low ADDR_W bits of the byte (5 bits at the default of 16 registers). It does not advance the pointer, and it returns the byte phase to low.
- R4: In manual mode (`manual_mode`=1) the pointer is unchanged after a complete word.
- R5: While the pointer is at or above NUM_REGS, `engine_run` is 0 and no register changes. `scan_word` shows register (pointer − NUM_REGS).
- R6: At a scan address, data-path strobes are ignored: registers, pointer and byte phase all stay the same.
- R7: Loading a pointer below NUM_REGS sets `engine_run` back to 1, with every register keeping its value.
- R8: A register never shows a half-written word. It keeps its old value after the low byte, and at most one register changes per clock.
- R9: `clr` high at once sets the pointer to 0, the phase to low and every register to 0, without waiting for a clock edge.
- R10: Each low pulse of `ld_n` causes exactly one action, however long it is held low.
- R11: While `engine_run` is 1, `scan_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clr | input | 1 | Asynchronous clear, active high |
| ld_n | input | 1 | Load strobe, active low, asynchronous to clk |
| ld_sel_addr | input | 1 | 1 = address path, 0 = data path |
| ld_byte | input | 8 | Byte being loaded |
| manual_mode | input | 1 | 1 = pointer fixed, 0 = pointer advances per word |
| cur_addr | output | ADDR_W | Current register pointer |
| hi_pending | output | 1 | 1 when a low byte is held and the high byte is awaited |
| engine_run | output | 1 | 0 while the pointer is a scan address |
| scan_word | output | 16 | Contents of the register selected for scan readout |
| regs_flat | output | NUM_REGS*16 | All registers, register i at bits i*16 +: 16 |

## Verification
Two actions can fall on the same clock edge: the commit of a finished word into its register and the move of the pointer. This is sharpest at register NUM_REGS-1, where the pointer wraps to 0. The bench loads the full bank in automatic mode and then writes the last register once more. It then checks that the word lands in the old register and not the new one, and that the pointer reads 0. The second case is entering scan while a low byte is pending. Here the address write must clear the phase, and the next register address must start a fresh word. The bench checks this with a half-loaded word followed by a scan address and then a register address.

// File: rtl/loader_pkg.sv
package loader_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic strobe_n,
    output logic fall
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], strobe_n};
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    // settled level went from high to low
    assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import loader_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              fall,
    input  logic              is_addr,
    input  byte_t             din,
    input  logic              manual,
    output logic [ADDR_W-1:0] addr,
    output logic              hi_wait,
    output logic              scan,
    output logic              wr_en,
    output word_t             wr_word
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        phase_e            ph;
        byte_t             lo;
    } st_t;

    st_t               s_d, s_q;
    logic [ADDR_W-1:0] nxt_addr;

    assign scan     = (s_q.addr >= ADDR_W'(NUM_REGS));
    assign nxt_addr = (s_q.addr == ADDR_W'(NUM_REGS - 1)) ? '0 : s_q.addr + 1'b1;

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_word = {din, s_q.lo};
        if (fall) begin
            if (is_addr) begin
                s_d.addr = din[ADDR_W-1:0];
                s_d.ph   = PH_LOW;
            end else if (!scan) begin
                if (s_q.ph == PH_LOW) begin
                    s_d.lo = din;
                    s_d.ph = PH_HIGH;
                end else begin
                    wr_en  = 1'b1;
                    s_d.ph = PH_LOW;
                    if (!manual) s_d.addr = nxt_addr;
                end
            end
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) s_q <= '{addr: '0, ph: PH_LOW, lo: '0};
        else     s_q <= s_d;
    end

    assign addr    = s_q.addr;
    assign hi_wait = (s_q.ph == PH_HIGH);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import loader_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 5
) (
    input  logic                         clk,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  word_t                        wr_word,
    input  logic                         scan,
    output word_t                        scan_word,
    output logic [NUM_REGS*WORD_W-1:0]   regs_flat
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_d, regs_q;
    logic [ADDR_W-1:0]               off;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr < ADDR_W'(NUM_REGS)))
            regs_d[wr_addr[IDX_W-1:0]] = wr_word;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign off = wr_addr - ADDR_W'(NUM_REGS);

    always_comb begin
        scan_word = '0;
        if (scan && (off < ADDR_W'(NUM_REGS)))
            scan_word = regs_q[off[IDX_W-1:0]];
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_flat
        assign regs_flat[gi*WORD_W +: WORD_W] = regs_q[gi];
    end
endmodule

// File: rtl/byte_loader.sv
module byte_loader
    import loader_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_REGS) + 1
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       ld_n,
    input  logic                       ld_sel_addr,
    input  logic [7:0]                 ld_byte,
    input  logic                       manual_mode,
    output logic [ADDR_W-1:0]          cur_addr,
    output logic                       hi_pending,
    output logic                       engine_run,
    output logic [15:0]                scan_word,
    output logic [NUM_REGS*16-1:0]     regs_flat
);
    logic  fall, scan, wr_en;
    word_t wr_word;

    strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .clr      (clr),
        .strobe_n (ld_n),
        .fall     (fall)
    );

    load_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) ctrl_i (
        .clk     (clk),
        .clr     (clr),
        .fall    (fall),
        .is_addr (ld_sel_addr),
        .din     (ld_byte),
        .manual  (manual_mode),
        .addr    (cur_addr),
        .hi_wait (hi_pending),
        .scan    (scan),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) bank_i (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_addr   (cur_addr),
        .wr_word   (wr_word),
        .scan      (scan),
        .scan_word (scan_word),
        .regs_flat (regs_flat)
    );

    assign engine_run = ~scan;
endmodule

// File: rtl/byte_loader_chk.sv
module byte_loader_chk #(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 5
) (
    input logic                   clk,
    input logic                   clr,
    input logic [ADDR_W-1:0]      cur_addr,
    input logic                   hi_pending,
    input logic                   engine_run,
    input logic [15:0]            scan_word,
    input logic [NUM_REGS*16-1:0] regs_flat
);
    logic [NUM_REGS*16-1:0] prev_q;
    logic [NUM_REGS-1:0]    chg;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) prev_q <= '0;
        else     prev_q <= regs_flat;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chg
        assign chg[gi] = regs_flat[gi*16 +: 16] != prev_q[gi*16 +: 16];
    end

    assert_single_commit_R8: assert property (@(posedge clk) disable iff (clr)
        $countones(chg) <= 1);

    assert_commit_on_high_R1: assert property (@(posedge clk) disable iff (clr)
        (|chg) |-> (!hi_pending && $past(hi_pending)));

    assert_addr_moves_phase_low_R3: assert property (@(posedge clk) disable iff (clr)
        (cur_addr != $past(cur_addr)) |-> !hi_pending);

    assert_scan_no_pending_R6: assert property (@(posedge clk) disable iff (clr)
        !engine_run |-> !hi_pending);

    assert_scan_frozen_R5: assert property (@(posedge clk) disable iff (clr)
        !engine_run |=> $stable(regs_flat));

    assert_run_no_readout_R11: assert property (@(posedge clk) disable iff (clr)
        engine_run |-> (scan_word == 16'h0));
endmodule

bind byte_loader byte_loader_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .clr        (clr),
    .cur_addr   (cur_addr),
    .hi_pending (hi_pending),
    .engine_run (engine_run),
    .scan_word  (scan_word),
    .regs_flat  (regs_flat)
);

// File: tb/byte_loader_tb_top.sv
`timescale 1ns/1ps
module byte_loader_tb_top;
    localparam int NR = 16;
    localparam int AW = 5;

    logic            clk = 0;
    logic            clr = 1;
    logic            ld_n = 1;
    logic            ld_sel_addr = 0;
    logic [7:0]      ld_byte = 0;
    logic            manual_mode = 0;
    logic [AW-1:0]   cur_addr;
    logic            hi_pending;
    logic            engine_run;
    logic [15:0]     scan_word;
    logic [NR*16-1:0] regs_flat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] exp_regs [NR];
    int          exp_addr;
    bit          exp_ph;
    logic [7:0]  exp_lo;

    always #2 clk = ~clk;

    byte_loader #(.NUM_REGS(NR)) dut_i (
        .clk(clk), .clr(clr), .ld_n(ld_n), .ld_sel_addr(ld_sel_addr),
        .ld_byte(ld_byte), .manual_mode(manual_mode), .cur_addr(cur_addr),
        .hi_pending(hi_pending), .engine_run(engine_run),
        .scan_word(scan_word), .regs_flat(regs_flat)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) exp_regs[i] = 16'h0;
        exp_addr = 0; exp_ph = 0; exp_lo = 0;
    endtask

    task automatic model_step(bit sel, logic [7:0] b);
        if (sel) begin
            exp_addr = int'(b) % 32; exp_ph = 0;
        end else if (exp_addr < NR) begin
            if (!exp_ph) begin
                exp_lo = b; exp_ph = 1;
            end else begin
                exp_regs[exp_addr] = {b, exp_lo}; exp_ph = 0;
                if (!manual_mode) exp_addr = (exp_addr == NR - 1) ? 0 : exp_addr + 1;
            end
        end
    endtask

    task automatic strobe(bit sel, logic [7:0] b, int hold = 6);
        model_step(sel, b);
        @(negedge clk);
        ld_sel_addr = sel; ld_byte = b; ld_n = 0;
        repeat (hold) @(negedge clk);
        ld_n = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(string req);
        chk(req, "cur_addr", int'(cur_addr), exp_addr);
        chk(req, "hi_pending", int'(hi_pending), int'(exp_ph));
        chk(req, "engine_run", int'(engine_run), (exp_addr < NR) ? 1 : 0);
        chk(req, "scan_word", int'(scan_word),
            (exp_addr >= NR && exp_addr - NR < NR) ? int'(exp_regs[exp_addr - NR]) : 0);
        for (int i = 0; i < NR; i++)
            chk(req, $sformatf("reg%0d", i), int'(regs_flat[i*16 +: 16]), int'(exp_regs[i]));
    endtask

    function automatic logic [15:0] pat(int i, int k);
        return 16'((i * 16'h1111) ^ 16'hA5C3 ^ (k * 16'h0707));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        clr = 0;
        repeat (2) @(negedge clk);
        check_all("R9 reset state");
        check_all("R11 idle readout");

        // R1 R2: fill the whole bank in automatic mode
        for (int i = 0; i < NR; i++) begin
            logic [15:0] w = pat(i, 1);
            strobe(0, w[7:0]);
            strobe(0, w[15:8]);
        end
        check_all("R1 R2 full bank auto load and wrap");

        // R2 wrap at last register: commit and pointer move on same edge
        strobe(1, 8'(NR - 1));
        check_all("R3 address load no increment");
        strobe(0, 8'h3C);
        check_all("R8 half word not visible");
        strobe(0, 8'hC3);
        check_all("R2 wrap from last register");

        // R4 manual mode
        manual_mode = 1;
        strobe(1, 8'd5);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] w = pat(5, k + 7);
            strobe(0, w[7:0]);
            strobe(0, w[15:8]);
            check_all("R4 manual pointer held");
        end
        manual_mode = 0;

        // R3 address write mid-word resets phase; upper byte bits dropped
        strobe(0, 8'h11);
        check_all("R8 pending low byte");
        strobe(1, 8'hE9);
        check_all("R3 phase reset, low bits only");
        strobe(0, 8'h22);
        strobe(0, 8'h44);
        check_all("R3 fresh word after address");

        // R5 scan sweep over every register
        for (int k = 0; k < NR; k++) begin
            strobe(1, 8'(NR + k));
            check_all("R5 scan readout");
        end
        // R6 data ignored at scan address, including after a pending low byte
        strobe(0, 8'hFF);
        strobe(0, 8'hEE);
        check_all("R6 scan data ignored");
        strobe(1, 8'd2);
        strobe(0, 8'h77);
        strobe(1, 8'(NR + 2));
        check_all("R6 scan entry clears pending");
        strobe(0, 8'h55);
        check_all("R6 scan data ignored again");

        // R7 resume
        strobe(1, 8'd3);
        check_all("R7 resume run");

        // R10 long hold gives one action
        strobe(0, 8'h9A, 40);
        check_all("R10 long low hold");
        strobe(0, 8'hB8, 2);
        check_all("R10 short pulse");

        // R9 asynchronous clear mid-word
        strobe(0, 8'h66);
        @(negedge clk);
        #1 clr = 1;
        #0.5;
        model_reset();
        check_all("R9 async clear");
        @(negedge clk);
        clr = 0;
        repeat (2) @(negedge clk);
        check_all("R9 after clear release");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule